// File: doc/BRIEF.md
# Change-of-Flow Address Trace FIFO

This block keeps a short, fixed-depth history of the program addresses at which control flow changed. Each cycle it looks at the execute-stage opcode address and a class code for the instruction retiring there. It also looks at a taken flag and a flag that says the opcode sits at an interrupt vector location. A qualifying address is pushed into the top of a shift-register store. Every older entry moves down one place, and the oldest entry falls off the bottom.

A debugger reads the history through a register-style port. The read data always shows the oldest entry. Each read pulse rotates that entry back in at the top, so a run of DEPTH reads returns the history oldest to newest and leaves the stored order as it was. A halt bit freezes capture in the same cycle it is set, so the history can be examined while the processor keeps running.

Top module: `cof_trace_fifo`

## Requirements
- R1: While rst_ni is low, every entry clears to zero, the halt bit clears, rd_data_o reads 0 and halted_o reads 0.
- R2: With exec_valid_i high, the class codes 1 (branch), 2 (jump), 5 (branch-if-bit-set), 6 (branch-if-bit-clear), 7 (subroutine return), 8 (interrupt return) and 9 (subroutine call) are captured whatever the state of taken_i.
- R3: Class codes 3 (conditional branch) and 4 (conditional jump) are captured only when taken_i is high. When taken_i is low the store is left unchanged.
- R4: Class 9 with at_vector_i high is not captured. at_vector_i has no effect on any other class.
- R5: A capture writes exec_addr_i into entry 0 at the next clock edge and moves entry k into entry k+1. The previous entry DEPTH-1 is discarded.
- R6: rd_data_o shows entry DEPTH-1, the oldest. A cycle with rd_en_i high moves entry DEPTH-1 to entry 0 and shifts the rest down one place. DEPTH consecutive reads therefore return the entries oldest first, newest last, and restore the original order.
- R7: halt_set_i blocks capture in the cycle it is high and sets the halt bit, which halted_o shows from the next cycle on. While the bit is set nothing is captured. halt_clr_i clears the bit, and halt_set_i wins when both are high.
- R8: A capture that coincides with rd_en_i high is dropped, and only the rotation takes place.
- R9: Nothing is captured when exec_valid_i is low, when the class is 0 (no change of flow), or when the class is one of the unused codes 10 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| exec_valid_i | input | 1 | An instruction executes this cycle |
| exec_addr_i | input | AW | Execute-stage opcode address |
| instr_class_i | input | 4 | Change-of-flow class code of the executing instruction |
| taken_i | input | 1 | Conditional transfer is taken |
| at_vector_i | input | 1 | Opcode lies at an interrupt vector location |
| halt_set_i | input | 1 | Set the capture halt bit |
| halt_clr_i | input | 1 | Clear the capture halt bit |
| rd_en_i | input | 1 | Read pulse: rotate the oldest entry to the top |
| rd_data_o | output | AW | Oldest stored address |
| halted_o | output | 1 | Capture halt bit |

## Verification
The assertions assume the class, taken and vector flags are valid whenever exec_valid_i is high. They also assume the halt set and clear controls are plain level requests sampled at the clock. The stimulus drives every input only on the falling edge and holds it for a whole cycle, so each request is seen at exactly one rising edge. The bench brings read pulses and captures together only in the directed test that targets R8, which keeps the other expected histories unambiguous.

// File: rtl/cof_pkg.sv
package cof_pkg;
  typedef enum logic [3:0] {
    CF_NONE  = 4'd0,
    CF_BRA   = 4'd1,
    CF_JMP   = 4'd2,
    CF_BCC   = 4'd3,
    CF_JCC   = 4'd4,
    CF_BRSET = 4'd5,
    CF_BRCLR = 4'd6,
    CF_RTS   = 4'd7,
    CF_RTI   = 4'd8,
    CF_JSR   = 4'd9
  } cf_class_e;

  localparam int unsigned CLASS_W = 4;
endpackage

// File: rtl/cof_qualify.sv
module cof_qualify
  import cof_pkg::*;
(
  input  logic               valid_i,
  input  logic [CLASS_W-1:0] class_i,
  input  logic               taken_i,
  input  logic               at_vector_i,
  output logic               hit_o
);
  logic cls_hit;

  always_comb begin
    unique case (class_i)
      CF_BRA, CF_JMP, CF_BRSET, CF_BRCLR,
      CF_RTS, CF_RTI:           cls_hit = 1'b1;
      CF_BCC, CF_JCC:           cls_hit = taken_i;
      CF_JSR:                   cls_hit = ~at_vector_i;  // vector-resident calls skipped
      default:                  cls_hit = 1'b0;
    endcase
  end

  assign hit_o = valid_i & cls_hit;
endmodule

// File: rtl/cof_halt_ctl.sv
module cof_halt_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic halted_o,
  output logic block_o
);
  logic halt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     halt_q <= 1'b0;
    else if (set_i)  halt_q <= 1'b1;
    else if (clr_i)  halt_q <= 1'b0;
  end

  assign halted_o = halt_q;
  // set acts in its own cycle, before the bit is visible
  assign block_o  = halt_q | set_i;
endmodule

// File: rtl/cof_shift_store.sv
module cof_shift_store #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      push_i,
  input  logic                      rot_i,
  input  logic [AW-1:0]             din_i,
  output logic [DEPTH-1:0][AW-1:0]  store_o,
  output logic [AW-1:0]             oldest_o
);
  localparam int unsigned LAST = DEPTH - 1;

  logic [DEPTH-1:0][AW-1:0] ent_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    if (i == 0) begin : g_top
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     ent_q[i] <= '0;
        else if (rot_i)  ent_q[i] <= ent_q[LAST];
        else if (push_i) ent_q[i] <= din_i;
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              ent_q[i] <= '0;
        else if (rot_i || push_i) ent_q[i] <= ent_q[i-1];
      end
    end
  end

  assign store_o  = ent_q;
  assign oldest_o = ent_q[LAST];
endmodule

// File: rtl/cof_trace_fifo.sv
module cof_trace_fifo
  import cof_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               exec_valid_i,
  input  logic [AW-1:0]      exec_addr_i,
  input  logic [CLASS_W-1:0] instr_class_i,
  input  logic               taken_i,
  input  logic               at_vector_i,
  input  logic               halt_set_i,
  input  logic               halt_clr_i,
  input  logic               rd_en_i,
  output logic [AW-1:0]      rd_data_o,
  output logic               halted_o
);
  logic                     hit;
  logic                     block;
  logic                     push;
  logic [DEPTH-1:0][AW-1:0] store;

  cof_qualify u_qual (
    .valid_i     (exec_valid_i),
    .class_i     (instr_class_i),
    .taken_i     (taken_i),
    .at_vector_i (at_vector_i),
    .hit_o       (hit)
  );

  cof_halt_ctl u_halt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (halt_set_i),
    .clr_i    (halt_clr_i),
    .halted_o (halted_o),
    .block_o  (block)
  );

  // read rotation wins over a coincident capture
  assign push = hit & ~block & ~rd_en_i;

  cof_shift_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (push),
    .rot_i    (rd_en_i),
    .din_i    (exec_addr_i),
    .store_o  (store),
    .oldest_o (rd_data_o)
  );
endmodule

// File: rtl/cof_trace_fifo_chk.sv
module cof_trace_fifo_chk
  import cof_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 16
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     exec_valid_i,
  input logic [AW-1:0]            exec_addr_i,
  input logic [CLASS_W-1:0]       instr_class_i,
  input logic                     taken_i,
  input logic                     at_vector_i,
  input logic                     halt_set_i,
  input logic                     rd_en_i,
  input logic [AW-1:0]            rd_data_o,
  input logic                     halted_o,
  input logic                     push,
  input logic [DEPTH-1:0][AW-1:0] store
);
  assert_push_top_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push |=> store[0] == $past(exec_addr_i));

  assert_rot_top_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> store[0] == $past(rd_data_o));

  assert_halt_freeze_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o || halt_set_i) && !rd_en_i |=> $stable(store));

  assert_halt_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_set_i |=> halted_o);

  assert_nottaken_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_class_i == CF_BCC || instr_class_i == CF_JCC) && !taken_i && !rd_en_i
    |=> $stable(store));

  assert_vector_call_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_class_i == CF_JSR && at_vector_i && !rd_en_i |=> $stable(store));

  assert_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_valid_i && !rd_en_i |=> $stable(store));

  assert_read_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |-> !push);
endmodule

bind cof_trace_fifo cof_trace_fifo_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .exec_valid_i  (exec_valid_i),
  .exec_addr_i   (exec_addr_i),
  .instr_class_i (instr_class_i),
  .taken_i       (taken_i),
  .at_vector_i   (at_vector_i),
  .halt_set_i    (halt_set_i),
  .rd_en_i       (rd_en_i),
  .rd_data_o     (rd_data_o),
  .halted_o      (halted_o),
  .push          (push),
  .store         (store)
);

// File: tb/cof_trace_fifo_tb.sv
module cof_trace_fifo_tb;
  localparam int unsigned DEPTH = 8;
  localparam int unsigned AW    = 16;
  localparam int unsigned NV    = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          exec_valid_i = 1'b0;
  logic [AW-1:0] exec_addr_i = '0;
  logic [3:0]    instr_class_i = '0;
  logic          taken_i = 1'b0;
  logic          at_vector_i = 1'b0;
  logic          halt_set_i = 1'b0;
  logic          halt_clr_i = 1'b0;
  logic          rd_en_i = 1'b0;
  logic [AW-1:0] rd_data_o;
  logic          halted_o;

  int n_run = 0;
  int n_fail = 0;
  logic [AW-1:0] mdl [DEPTH];

  always #4 clk_i = ~clk_i;  // 125 MHz

  cof_trace_fifo #(.DEPTH(DEPTH), .AW(AW)) u_dut (.*);

  // {valid, class, taken, at_vector, addr, expect_capture}
  localparam logic [23:0] VEC [NV] = '{
    {1'b1, 4'd1,  1'b0, 1'b0, 16'h1000, 1'b1},  // R2 branch
    {1'b1, 4'd3,  1'b1, 1'b0, 16'h1010, 1'b1},  // R3 cond branch taken
    {1'b1, 4'd3,  1'b0, 1'b0, 16'h1020, 1'b0},  // R3 not taken
    {1'b1, 4'd4,  1'b1, 1'b0, 16'h1030, 1'b1},  // R3 cond jump taken
    {1'b1, 4'd4,  1'b0, 1'b0, 16'h1040, 1'b0},  // R3 not taken
    {1'b1, 4'd9,  1'b0, 1'b1, 16'h1050, 1'b0},  // R4 vector call
    {1'b1, 4'd9,  1'b0, 1'b0, 16'h1060, 1'b1},  // R2 call
    {1'b1, 4'd7,  1'b0, 1'b1, 16'h1070, 1'b1},  // R4 vector flag ignored
    {1'b1, 4'd0,  1'b1, 1'b0, 16'h1080, 1'b0},  // R9 none
    {1'b1, 4'd12, 1'b1, 1'b0, 16'h1090, 1'b0},  // R9 unused code
    {1'b1, 4'd5,  1'b0, 1'b0, 16'h10A0, 1'b1},  // R2 bit set
    {1'b1, 4'd8,  1'b0, 1'b0, 16'h10B0, 1'b1},  // R2 int return
    {1'b1, 4'd6,  1'b0, 1'b0, 16'h10C0, 1'b1},  // R2 bit clear
    {1'b1, 4'd2,  1'b0, 1'b0, 16'h10D0, 1'b1},  // R2 jump
    {1'b1, 4'd7,  1'b1, 1'b0, 16'h10E0, 1'b1},  // R5 overflow discards oldest
    {1'b0, 4'd2,  1'b0, 1'b0, 16'h10F0, 1'b0}   // R9 invalid
  };

  task automatic chk(input logic [AW-1:0] act, input logic [AW-1:0] exp, input string req);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic m_push(input logic [AW-1:0] a);
    for (int k = DEPTH - 1; k > 0; k--) mdl[k] = mdl[k-1];
    mdl[0] = a;
  endtask

  task automatic m_rot();
    logic [AW-1:0] t;
    t = mdl[DEPTH-1];
    for (int k = DEPTH - 1; k > 0; k--) mdl[k] = mdl[k-1];
    mdl[0] = t;
  endtask

  task automatic exec(input logic v, input logic [3:0] c, input logic tk,
                      input logic vc, input logic [AW-1:0] a, input logic rd);
    @(negedge clk_i);
    exec_valid_i = v; instr_class_i = c; taken_i = tk; at_vector_i = vc;
    exec_addr_i = a; rd_en_i = rd;
    @(negedge clk_i);
    exec_valid_i = 1'b0; rd_en_i = 1'b0; taken_i = 1'b0; at_vector_i = 1'b0;
  endtask

  task automatic read_one(input string req);
    @(negedge clk_i);
    chk(rd_data_o, mdl[DEPTH-1], req);
    rd_en_i = 1'b1;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    m_rot();
  endtask

  task automatic read_all(input string req);
    for (int k = 0; k < DEPTH; k++) read_one(req);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int k = 0; k < DEPTH; k++) mdl[k] = '0;
    // R1: reset state
    repeat (2) @(negedge clk_i);
    chk(rd_data_o, '0, "R1 rd_data");
    chk({15'd0, halted_o}, '0, "R1 halted");
    rst_ni = 1'b1;

    // table walk: R2 R3 R4 R5 R9
    for (int v = 0; v < NV; v++) begin
      exec(VEC[v][23], VEC[v][22:19], VEC[v][18], VEC[v][17], VEC[v][16:1], 1'b0);
      if (VEC[v][0]) m_push(VEC[v][16:1]);
      chk(rd_data_o, mdl[DEPTH-1], $sformatf("R5 vec%0d oldest", v));
    end
    read_all("R6 ordered readout");
    // R6: full read restores order
    read_all("R6 order restored");

    // R7: halt set in the same cycle as a jump
    @(negedge clk_i); halt_set_i = 1'b1;
    exec_valid_i = 1'b1; instr_class_i = 4'd2; exec_addr_i = 16'h2000;
    @(negedge clk_i); halt_set_i = 1'b0; exec_valid_i = 1'b0;
    chk({15'd0, halted_o}, 16'd1, "R7 halted_o");
    exec(1'b1, 4'd1, 1'b0, 1'b0, 16'h2010, 1'b0);
    read_all("R7 frozen while halted");
    // R7: set beats clear
    @(negedge clk_i); halt_set_i = 1'b1; halt_clr_i = 1'b1;
    @(negedge clk_i); halt_set_i = 1'b0; halt_clr_i = 1'b0;
    chk({15'd0, halted_o}, 16'd1, "R7 set priority");
    @(negedge clk_i); halt_clr_i = 1'b1;
    @(negedge clk_i); halt_clr_i = 1'b0;
    chk({15'd0, halted_o}, 16'd0, "R7 cleared");
    exec(1'b1, 4'd8, 1'b0, 1'b0, 16'h2020, 1'b0);
    m_push(16'h2020);

    // R8: read and capture in the same cycle
    exec(1'b1, 4'd2, 1'b0, 1'b0, 16'h2030, 1'b1);
    m_rot();
    read_all("R8 capture dropped on read");

    // R1: reset mid-run clears store and halt
    @(negedge clk_i); halt_set_i = 1'b1;
    @(negedge clk_i); halt_set_i = 1'b0; rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    chk({15'd0, halted_o}, 16'd0, "R1 halt released");
    for (int k = 0; k < DEPTH; k++) mdl[k] = '0;
    read_all("R1 entries cleared");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule